// File: doc/BRIEF.md
# Flash Suspend/Resume Command Controller

This block sequences long operations in a flash array built from many independent planes. It lets the host pause an erase or a program operation and later continue it. The host sends single-cycle commands, each made of an operation code, a plane address and a sector address. The block keeps one slot for an erase and one slot for a program. Each slot counts down the remaining busy time. A suspend request is honoured after a fixed latency, and the remaining time is frozen until a resume arrives.

The suspend command uses one code and needs no address. The resume command also uses one shared code, and the block decides whether it refers to the program or to the erase from its own state. A resume that continues an erase must name the plane that holds the suspended sector. While a suspend is in force, each incoming command is checked against the list of commands allowed in that mode. A command that is not allowed is dropped and raises a sticky error flag. A program may be started inside an erase suspend and then suspended in turn. The two are then unwound in order: the program first, then the erase.

Top module: `fsr_ctrl`

## Requirements
- R1: After reset, `rdy` is 1, `susp_mode` is 0, `esr_planes` is all zero, and both `err_flag` and `cmd_rej` are 0.
- R2: From idle, the codes program (4), sector erase (5), plane erase (6) and chip erase (7) start an operation. `rdy` falls in the cycle after the command and rises again exactly PROG_CYC, SE_CYC, PE_CYC or CE_CYC cycles after the command cycle.
- R3: The suspend code (8), sent while a program or a sector/plane erase runs, raises `rdy` exactly PSUSP_LAT (program) or ESUSP_LAT (erase) cycles after the command cycle. `susp_mode` bit 1 (program held) or bit 0 (erase held) is then set. The defaults of 500 and 750 cycles equal 10 µs and 15 µs at 50 MHz.
- R4: The suspend code sent during a chip erase is ignored. No rejection and no error are raised, and the erase completes CE_CYC cycles after its start.
- R5: The cycle of the suspend command counts as run time. With the start in cycle t, the suspend in cycle s and the resume code (9) in cycle r, the operation of length N completes in cycle r + N - (s - t). A held slot stays held until it is resumed.
- R6: An erase resume whose plane does not equal the plane of the suspended erase is rejected: `cmd_rej` pulses, `err_flag` is set and the erase stays held.
- R7: While an erase is held, `esr_planes` has exactly one bit set, at the index equal to the suspended plane address. Otherwise `esr_planes` is zero.
- R8: While only an erase is held and nothing runs, codes 0, 1, 2, 3, 4, 8, 9, 10 and 11 are legal. Every other code (5, 6, 7, 12 to 15) is rejected: `cmd_rej` is 1 in the cycle after the command and `err_flag` becomes 1.
- R9: During an erase suspend, a program is rejected if it targets the suspended sector (same plane and sector after a sector erase, or same plane after a plane erase). Any other program starts and runs for PROG_CYC cycles.
- R10: While a program is held, only codes 0, 1, 2 and 9 are legal. All other codes are rejected.
- R11: A program suspended inside an erase suspend gives `susp_mode` = 3. The first resume continues the program whatever plane it carries, and `susp_mode` becomes 1. A later resume carrying the erase plane continues the erase.
- R12: A suspend that arrives in the final cycle of an operation is ignored. The operation completes, and `rdy` = 1 and `susp_mode` = 0 follow.
- R13: While an operation runs or a suspend is pending, only codes 0, 1 and 8 are accepted, and all others are rejected. `err_flag` stays set until a clear-status command (3) is accepted, in idle or during an erase suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 4 | Operation code |
| cmd_plane | input | PLANE_W | Plane address |
| cmd_sector | input | SECT_W | Sector address within the plane |
| rdy | output | 1 | 1 when nothing runs and no suspend is pending |
| susp_mode | output | 2 | Bit 0: erase held; bit 1: program held |
| esr_planes | output | 2**PLANE_W | One-hot plane in erase-suspend-read mode |
| err_flag | output | 1 | Sticky illegal-command flag |
| cmd_rej | output | 1 | Pulse one cycle after a rejected command |

## Verification
An operation's final countdown cycle and a suspend request can land on the same clock edge. The bench provokes this by timing the suspend to the start cycle plus the operation length. It then judges that completion wins: `rdy` rises, `susp_mode` stays 0 and nothing is rejected. Command filtering also runs in the same cycles as an operation's countdown. Random codes sent during a running chip erase, during an erase hold and during a program hold are each compared with the legality lists written out in the requirements.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [3:0] {
        OP_RD       = 4'd0,
        OP_RDSTAT   = 4'd1,
        OP_IDENT    = 4'd2,
        OP_CLRST    = 4'd3,
        OP_PROG     = 4'd4,
        OP_SECT_ER  = 4'd5,
        OP_PLANE_ER = 4'd6,
        OP_CHIP_ER  = 4'd7,
        OP_SUSPEND  = 4'd8,
        OP_RESUME   = 4'd9,
        OP_LOCK     = 4'd10,
        OP_UNLOCK   = 4'd11
    } op_e;

    typedef enum logic [1:0] {
        SL_IDLE = 2'd0,
        SL_RUN  = 2'd1,
        SL_WAIT = 2'd2,
        SL_HELD = 2'd3
    } slot_st_e;

    typedef enum logic [1:0] {
        EK_SECT  = 2'd0,
        EK_PLANE = 2'd1,
        EK_CHIP  = 2'd2
    } ekind_e;

    typedef struct packed {
        logic   start_prog;
        logic   start_erase;
        ekind_e kind;
        logic   susp_e;
        logic   susp_p;
        logic   res_e;
        logic   res_p;
        logic   clr;
        logic   reject;
    } act_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Codes accepted while a countdown or a suspend latency is running
    function automatic logic busy_ok(input logic [3:0] op);
        return (op == OP_RD) || (op == OP_RDSTAT) || (op == OP_SUSPEND);
    endfunction

    // Codes accepted while a program is held
    function automatic logic psusp_ok(input logic [3:0] op);
        return (op == OP_RD) || (op == OP_RDSTAT) || (op == OP_IDENT) ||
               (op == OP_RESUME);
    endfunction

    // Codes accepted while only an erase is held
    function automatic logic esusp_ok(input logic [3:0] op);
        return (op == OP_RD)      || (op == OP_RDSTAT) || (op == OP_IDENT) ||
               (op == OP_CLRST)   || (op == OP_PROG)   || (op == OP_SUSPEND) ||
               (op == OP_RESUME)  || (op == OP_LOCK)   || (op == OP_UNLOCK);
    endfunction

    function automatic ekind_e kind_of(input logic [3:0] op);
        case (op)
            OP_PLANE_ER: return EK_PLANE;
            OP_CHIP_ER:  return EK_CHIP;
            default:     return EK_SECT;
        endcase
    endfunction

endpackage

// File: rtl/fsr_slot.sv
module fsr_slot
    import fsr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LAT   = 500
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] start_len,
    input  logic             susp_req,
    input  logic             resume_req,
    output slot_st_e         st
);
    localparam int LAT_W = $clog2(LAT + 1);

    logic [CNT_W-1:0] rem;
    logic [LAT_W-1:0] lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SL_IDLE;
            rem <= '0;
            lat <= '0;
        end else begin
            case (st)
                SL_IDLE: begin
                    if (start) begin
                        st  <= SL_RUN;
                        rem <= start_len;
                    end
                end
                SL_RUN: begin
                    if (rem <= CNT_W'(1)) begin
                        st <= SL_IDLE;          // completion wins over suspend
                    end else begin
                        rem <= rem - CNT_W'(1);
                        if (susp_req) begin
                            st  <= SL_WAIT;
                            lat <= LAT_W'(LAT);
                        end
                    end
                end
                SL_WAIT: begin
                    if (lat <= LAT_W'(1)) st <= SL_HELD;
                    else                  lat <= lat - LAT_W'(1);
                end
                SL_HELD: begin
                    if (resume_req) st <= SL_RUN;
                end
                default: st <= SL_IDLE;
            endcase
        end
    end

    // Independent count of cycles spent waiting for the suspend to settle
    logic [LAT_W:0] wait_cnt;
    always_ff @(posedge clk) begin
        if (rst || st != SL_WAIT) wait_cnt <= '0;
        else                      wait_cnt <= wait_cnt + 1'b1;
    end

    AST_SUSP_WITHIN_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st == SL_WAIT) |-> (wait_cnt < (LAT_W+1)'(LAT))); // R3
    AST_HOLD_UNTIL_RESUME: assert property (@(posedge clk) disable iff (rst)
        (st == SL_HELD && !resume_req) |=> (st == SL_HELD)); // R5
    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> (st == SL_IDLE)); // R13

endmodule

// File: rtl/fsr_filter.sv
module fsr_filter
    import fsr_pkg::*;
#(
    parameter int PLANE_W = 5,
    parameter int SECT_W  = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [3:0]         cmd_op,
    input  logic [PLANE_W-1:0] cmd_plane,
    input  logic [SECT_W-1:0]  cmd_sector,
    input  slot_st_e           e_st,
    input  slot_st_e           p_st,
    input  ekind_e             e_kind,
    input  logic [PLANE_W-1:0] e_plane,
    input  logic [SECT_W-1:0]  e_sector,
    output act_t               act
);
    logic busy;
    logic hits_erased;

    assign busy = (e_st == SL_RUN) || (e_st == SL_WAIT) ||
                  (p_st == SL_RUN) || (p_st == SL_WAIT);

    assign hits_erased = (cmd_plane == e_plane) &&
                         ((e_kind == EK_PLANE) || (cmd_sector == e_sector));

    always_comb begin
        act = '0;
        if (cmd_valid) begin
            if (busy) begin
                if (cmd_op == OP_SUSPEND) begin
                    if (p_st == SL_RUN)                            act.susp_p = 1'b1;
                    else if (e_st == SL_RUN && e_kind != EK_CHIP)  act.susp_e = 1'b1;
                end else if (!busy_ok(cmd_op)) begin
                    act.reject = 1'b1;
                end
            end else if (p_st == SL_HELD) begin
                if (cmd_op == OP_RESUME)      act.res_p  = 1'b1;
                else if (!psusp_ok(cmd_op))   act.reject = 1'b1;
            end else if (e_st == SL_HELD) begin
                if (!esusp_ok(cmd_op)) begin
                    act.reject = 1'b1;
                end else if (cmd_op == OP_RESUME) begin
                    if (cmd_plane == e_plane) act.res_e  = 1'b1;
                    else                      act.reject = 1'b1;
                end else if (cmd_op == OP_PROG) begin
                    if (hits_erased) act.reject     = 1'b1;
                    else             act.start_prog = 1'b1;
                end else if (cmd_op == OP_CLRST) begin
                    act.clr = 1'b1;
                end
            end else begin
                case (cmd_op)
                    OP_PROG:  act.start_prog = 1'b1;
                    OP_SECT_ER, OP_PLANE_ER, OP_CHIP_ER: begin
                        act.start_erase = 1'b1;
                        act.kind        = kind_of(cmd_op);
                    end
                    OP_CLRST: act.clr = 1'b1;
                    default:  ;
                endcase
            end
        end
    end

    AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (rst)
        $onehot0({act.start_prog, act.start_erase, act.susp_e, act.susp_p,
                  act.res_e, act.res_p, act.clr, act.reject})); // R13

endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
    import fsr_pkg::*;
#(
    parameter int PLANE_W   = 5,
    parameter int SECT_W    = 6,
    parameter int PROG_CYC  = 1000,
    parameter int SE_CYC    = 50000,
    parameter int PE_CYC    = 100000,
    parameter int CE_CYC    = 400000,
    parameter int ESUSP_LAT = 750,
    parameter int PSUSP_LAT = 500
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cmd_valid,
    input  logic [3:0]              cmd_op,
    input  logic [PLANE_W-1:0]      cmd_plane,
    input  logic [SECT_W-1:0]       cmd_sector,
    output logic                    rdy,
    output logic [1:0]              susp_mode,
    output logic [(1<<PLANE_W)-1:0] esr_planes,
    output logic                    err_flag,
    output logic                    cmd_rej
);
    localparam int N_PLANES = 1 << PLANE_W;
    localparam int LEN_MAX  = max_of(max_of(PROG_CYC, SE_CYC), max_of(PE_CYC, CE_CYC));
    localparam int CNT_W    = $clog2(LEN_MAX + 1);

    act_t               act;
    slot_st_e           e_st, p_st;
    ekind_e             e_kind_q;
    logic [PLANE_W-1:0] e_plane_q;
    logic [SECT_W-1:0]  e_sector_q;
    logic [CNT_W-1:0]   erase_len;

    fsr_filter #(.PLANE_W(PLANE_W), .SECT_W(SECT_W)) u_filter (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_plane  (cmd_plane),
        .cmd_sector (cmd_sector),
        .e_st       (e_st),
        .p_st       (p_st),
        .e_kind     (e_kind_q),
        .e_plane    (e_plane_q),
        .e_sector   (e_sector_q),
        .act        (act)
    );

    always_comb begin
        case (act.kind)
            EK_PLANE: erase_len = CNT_W'(PE_CYC);
            EK_CHIP:  erase_len = CNT_W'(CE_CYC);
            default:  erase_len = CNT_W'(SE_CYC);
        endcase
    end

    fsr_slot #(.CNT_W(CNT_W), .LAT(ESUSP_LAT)) u_erase (
        .clk        (clk),
        .rst        (rst),
        .start      (act.start_erase),
        .start_len  (erase_len),
        .susp_req   (act.susp_e),
        .resume_req (act.res_e),
        .st         (e_st)
    );

    fsr_slot #(.CNT_W(CNT_W), .LAT(PSUSP_LAT)) u_prog (
        .clk        (clk),
        .rst        (rst),
        .start      (act.start_prog),
        .start_len  (CNT_W'(PROG_CYC)),
        .susp_req   (act.susp_p),
        .resume_req (act.res_p),
        .st         (p_st)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            e_kind_q   <= EK_SECT;
            e_plane_q  <= '0;
            e_sector_q <= '0;
        end else if (act.start_erase) begin
            e_kind_q   <= act.kind;
            e_plane_q  <= cmd_plane;
            e_sector_q <= cmd_sector;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_flag <= 1'b0;
            cmd_rej  <= 1'b0;
        end else begin
            cmd_rej <= act.reject;
            if (act.reject)   err_flag <= 1'b1;
            else if (act.clr) err_flag <= 1'b0;
        end
    end

    assign rdy       = !((e_st == SL_RUN) || (e_st == SL_WAIT) ||
                         (p_st == SL_RUN) || (p_st == SL_WAIT));
    assign susp_mode = {p_st == SL_HELD, e_st == SL_HELD};

    for (genvar i = 0; i < N_PLANES; i++) begin : g_esr
        assign esr_planes[i] = (e_st == SL_HELD) && (e_plane_q == PLANE_W'(i));
    end

    AST_CHIP_NEVER_HELD: assert property (@(posedge clk) disable iff (rst)
        (e_kind_q == EK_CHIP) |-> (e_st == SL_IDLE || e_st == SL_RUN)); // R4
    AST_ESR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(esr_planes)); // R7
    AST_REJ_FLAGS_ERR: assert property (@(posedge clk) disable iff (rst)
        cmd_rej |-> err_flag); // R8
    AST_NEST_ORDER: assert property (@(posedge clk) disable iff (rst)
        (p_st == SL_HELD) |-> (e_st == SL_IDLE || e_st == SL_HELD)); // R11

endmodule

// File: tb/sim_fsr_ctrl.sv
`timescale 1ns/1ps
module sim_fsr_ctrl;
    localparam int PW   = 3;
    localparam int SW   = 4;
    localparam int PROG = 12;
    localparam int SE   = 40;
    localparam int PE   = 50;
    localparam int CE   = 60;
    localparam int ELAT = 7;
    localparam int PLAT = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [3:0]    cmd_op = '0;
    logic [PW-1:0] cmd_plane = '0;
    logic [SW-1:0] cmd_sector = '0;
    logic          rdy;
    logic [1:0]    susp_mode;
    logic [7:0]    esr_planes;
    logic          err_flag;
    logic          cmd_rej;

    int n_chk = 0;
    int n_bad = 0;
    int unsigned seed = 32'h5EED_1234;

    fsr_ctrl #(
        .PLANE_W(PW), .SECT_W(SW), .PROG_CYC(PROG), .SE_CYC(SE), .PE_CYC(PE),
        .CE_CYC(CE), .ESUSP_LAT(ELAT), .PSUSP_LAT(PLAT)
    ) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_plane(cmd_plane), .cmd_sector(cmd_sector), .rdy(rdy),
        .susp_mode(susp_mode), .esr_planes(esr_planes), .err_flag(err_flag),
        .cmd_rej(cmd_rej)
    );

    always #10 clk = ~clk;

    // Legality lists taken from the requirements
    function automatic bit exp_busy_ok(int op);  return op inside {0, 1, 8}; endfunction          // R13
    function automatic bit exp_ps_ok(int op);    return op inside {0, 1, 2, 9}; endfunction       // R10
    function automatic bit exp_es_ok(int op);    return op inside {0,1,2,3,4,8,9,10,11}; endfunction // R8

    task automatic chk(int act, int exp, string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue(int op, int plane, int sector);
        cmd_op     = 4'(op);
        cmd_plane  = PW'(plane);
        cmd_sector = SW'(sector);
        cmd_valid  = 1'b1;
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    task automatic wait_ready(int n, string req);
        tick(n - 1);
        chk(int'(rdy), 0, req);
        tick(1);
        chk(int'(rdy), 1, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    int es_pool[12] = '{0, 1, 2, 5, 6, 7, 10, 11, 12, 13, 14, 15};

    initial begin
        void'($urandom(seed));
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk(int'(rdy), 1, "R1");
        chk(int'(susp_mode), 0, "R1");
        chk(int'(esr_planes), 0, "R1");
        chk(int'(err_flag), 0, "R1");
        chk(int'(cmd_rej), 0, "R1");

        // R2 plain operation lengths
        issue(4, 2, 1); wait_ready(PROG, "R2");
        issue(5, 1, 3); wait_ready(SE, "R2");
        issue(6, 4, 0); wait_ready(PE, "R2");

        // R4 chip erase ignores suspend; R13 random codes while busy
        issue(7, 0, 0);
        tick(2);
        issue(8, 0, 0);
        chk(int'(cmd_rej), 0, "R4");
        chk(int'(err_flag), 0, "R4");
        for (int i = 0; i < 8; i++) begin
            int op = $urandom_range(0, 15);
            issue(op, $urandom_range(0, 7), 0);
            chk(int'(cmd_rej), exp_busy_ok(op) ? 0 : 1, "R13");
        end
        tick(CE - 11 - 1);
        chk(int'(rdy), 0, "R4");
        tick(1);
        chk(int'(rdy), 1, "R4");
        issue(3, 0, 0);
        chk(int'(err_flag), 0, "R13");

        // R12 suspend on the final cycle: completion wins
        issue(5, 0, 0);
        tick(SE - 1);
        issue(8, 0, 0);
        chk(int'(rdy), 1, "R12");
        chk(int'(susp_mode), 0, "R12");
        chk(int'(cmd_rej), 0, "R12");

        // R3/R10/R5 program suspend, random codes, resume
        issue(4, 4, 2);
        tick(3);
        issue(8, 0, 0);                 // k = 4, remaining 8
        tick(PLAT - 1);
        chk(int'(rdy), 0, "R3");
        tick(1);
        chk(int'(rdy), 1, "R3");
        chk(int'(susp_mode), 2, "R3");
        for (int i = 0; i < 12; i++) begin
            int op = $urandom_range(0, 15);
            if (op == 9) op = 0;
            issue(op, $urandom_range(0, 7), $urandom_range(0, 15));
            chk(int'(cmd_rej), exp_ps_ok(op) ? 0 : 1, "R10");
            chk(int'(susp_mode), 2, "R10");
        end
        issue(9, 7, 0);
        chk(int'(susp_mode), 0, "R5");
        wait_ready(PROG - 4, "R5");

        // Erase suspend on plane 5 sector 9
        issue(5, 5, 9);
        tick(9);
        issue(8, 0, 0);                 // k = 10, remaining 30
        tick(ELAT - 1);
        chk(int'(rdy), 0, "R3");
        tick(1);
        chk(int'(rdy), 1, "R3");
        chk(int'(susp_mode), 1, "R3");
        chk(int'(esr_planes), 32, "R7");
        for (int i = 0; i < 16; i++) begin
            int op = es_pool[$urandom_range(0, 11)];
            issue(op, $urandom_range(0, 7), $urandom_range(0, 15));
            chk(int'(cmd_rej), exp_es_ok(op) ? 0 : 1, "R8");
            if (!exp_es_ok(op)) chk(int'(err_flag), 1, "R8");
            chk(int'(susp_mode), 1, "R8");
        end
        issue(9, 2, 0);
        chk(int'(cmd_rej), 1, "R6");
        chk(int'(err_flag), 1, "R6");
        chk(int'(susp_mode), 1, "R6");
        issue(3, 0, 0);
        chk(int'(err_flag), 0, "R13");
        issue(4, 5, 9);
        chk(int'(cmd_rej), 1, "R9");
        issue(4, 5, 8);
        chk(int'(cmd_rej), 0, "R9");
        wait_ready(PROG, "R9");
        chk(int'(susp_mode), 1, "R9");

        // R11 nested suspend
        issue(4, 1, 0);
        tick(2);
        issue(8, 0, 0);                 // k = 3, remaining 9
        tick(PLAT - 1);
        chk(int'(rdy), 0, "R11");
        tick(1);
        chk(int'(susp_mode), 3, "R11");
        chk(int'(esr_planes), 32, "R7");
        issue(9, 6, 0);
        chk(int'(susp_mode), 1, "R11");
        wait_ready(PROG - 3, "R11");
        chk(int'(susp_mode), 1, "R11");
        issue(9, 5, 0);
        chk(int'(susp_mode), 0, "R11");
        chk(int'(esr_planes), 0, "R7");
        wait_ready(SE - 10, "R5");

        // R9 plane erase blocks the whole plane
        issue(6, 2, 0);
        tick(4);
        issue(8, 0, 0);                 // k = 5, remaining 45
        tick(ELAT);
        chk(int'(susp_mode), 1, "R3");
        chk(int'(esr_planes), 4, "R7");
        issue(4, 2, 11);
        chk(int'(cmd_rej), 1, "R9");
        issue(4, 3, 11);
        chk(int'(cmd_rej), 0, "R9");
        wait_ready(PROG, "R9");
        issue(9, 2, 0);
        wait_ready(PE - 5, "R5");
        chk(int'(susp_mode), 0, "R5");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule